// File: doc/BRIEF.md
# Private Single-Level Accelerator Cache Controller

This block is a small private cache that sits between an accelerator core and a coherence guard. The guard offers a fixed, simplified message set. The core issues one load or store at a time on a request/acknowledge port. The cache holds a direct-mapped array of single-word lines. Each line is in one of five states: invalid (I), shared (S), exclusive (E), modified (M) or busy (B). B stands for any outstanding Get or Put on that line. The controller answers hits locally and turns misses, upgrades and conflict evictions into Get and Put messages. It answers every invalidation the guard sends. The guard handles all host-side ack counting and races, so the controller only tracks its own single outstanding transaction.

A controller state machine with three states steers the line states:

- **IDLE**
  - Serves core requests.
  - Load hit in S, E or M: returns the data.
  - Store hit in E or M: writes the data and the line becomes M. A store hit in E makes no coherence message.
  - Store hit in S: sends GetM and the line goes to B. This is the upgrade transition.
  - Miss on an I line: sends GetS for a load or GetM for a store. The line goes to B with its new tag.
  - Miss on a valid line with another tag: sends PutS, PutE or PutM for the resident line. The line goes to B with its old tag.
- **WAIT_FILL**
  - Left on DataS, DataE or DataM. The fill installs the line in S, E or M.
- **WAIT_WB**
  - Left on the writeback ack. The line goes to I.

After either wait state ends, the core's held request is evaluated again from IDLE.

An Invalidate arriving in any controller state gets a reply:

- On a line in M: a Dirty Writeback, and the line goes to I.
- On a line in E: a Clean Writeback, and the line goes to I.
- On a line in S: an InvAck, and the line goes to I.
- On a line that is I, B, or holds another tag: an InvAck, and nothing changes.

Top module: `acc_cache_ctrl`

## Requirements
- R1: After reset every line is I. Outputs `core_ack` and `out_valid` are low, and the first access to any address misses.
- R2: A load miss sends GetS (out code 0) and a store miss sends GetM (out code 1). The message carries the request address and appears in the cycle after the request is taken.
- R3: A fill installs DataS (in code 0) as S, DataE (in code 1) as E and DataM (in code 2) as M. After the fill, the held request is served one cycle later.
- R4: A load hit raises `core_ack` for one cycle, one cycle after the request, with the line's data on `core_rdata`. It sends no message.
- R5: A store hit in E or M writes the word and leaves the line in M, with no message. A later Invalidate returns the stored word.
- R6: A store hit in S sends GetM (code 1). The core stalls until DataM (code 2) arrives, and the store is then applied.
- R7: A miss whose line holds another valid tag first sends PutM (code 4, with the data), PutE (code 3) or PutS (code 2). The choice follows the resident state, and the Put carries the resident address. The Get follows only after that.
- R8: A Put completes only on the writeback ack (in code 3). Until then no Get is sent and the core receives no ack.
- R9: An Invalidate (in code 4) on a resident line is answered in the next cycle, echoing its address, and the line goes to I:
  - from M: Dirty Writeback (code 7) carrying the data;
  - from E: Clean Writeback (code 6);
  - from S: InvAck (code 5).
- R10: An Invalidate for a line whose Put is outstanding is answered with InvAck (code 5). The controller keeps waiting for the writeback ack.
- R11: An Invalidate for an absent address (line I or another tag) is answered with InvAck (code 5) and changes no line.
- R12: An incoming message in the same cycle as a core request takes precedence. The core request is served in a later cycle.
- R13: `core_ack` lasts one cycle. A request still held in the cycle after an ack is served again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request, held until acknowledged |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Store data |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load data, valid with `core_ack` |
| out_valid | output | 1 | Outgoing coherence message valid (one-cycle pulse) |
| out_type | output | 3 | Outgoing message code |
| out_addr | output | ADDR_W | Outgoing message address |
| out_data | output | DATA_W | Outgoing message data (Put/writeback) |
| in_valid | input | 1 | Incoming coherence message valid |
| in_type | input | 3 | Incoming message code |
| in_addr | input | ADDR_W | Incoming message address |
| in_data | input | DATA_W | Incoming fill data |

## Verification
The bench builds the block with its defaults: 8-bit word addresses, 16 lines and 32-bit data. This gives a 4-bit tag and leaves many tags per index. Addresses such as 0x05, 0x15, 0x25 and 0x35 all fall on one line. That drives every Put flavour, a Put crossed by an Invalidate, and an Invalidate whose tag differs from the resident one. Each fill code and each reply code is reached, so all five line states and all three controller states are visited.

// File: rtl/acc_cc_pkg.sv
package acc_cc_pkg;

    typedef enum logic [2:0] {
        LN_I = 3'd0,
        LN_S = 3'd1,
        LN_E = 3'd2,
        LN_M = 3'd3,
        LN_B = 3'd4
    } line_st_t;

    typedef enum logic [2:0] {
        OM_GETS    = 3'd0,
        OM_GETM    = 3'd1,
        OM_PUTS    = 3'd2,
        OM_PUTE    = 3'd3,
        OM_PUTM    = 3'd4,
        OM_INVACK  = 3'd5,
        OM_CLEANWB = 3'd6,
        OM_DIRTYWB = 3'd7
    } out_msg_t;

    typedef enum logic [2:0] {
        IM_DATAS = 3'd0,
        IM_DATAE = 3'd1,
        IM_DATAM = 3'd2,
        IM_WBACK = 3'd3,
        IM_INV   = 3'd4
    } in_msg_t;

    typedef enum logic [1:0] {
        C_IDLE      = 2'd0,
        C_WAIT_WB   = 2'd1,
        C_WAIT_FILL = 2'd2
    } ctl_st_t;

    function automatic logic holds_copy(line_st_t s);
        return (s == LN_S) || (s == LN_E) || (s == LN_M);
    endfunction

    function automatic out_msg_t put_for(line_st_t s);
        unique case (s)
            LN_M:    return OM_PUTM;
            LN_E:    return OM_PUTE;
            default: return OM_PUTS;
        endcase
    endfunction

    function automatic line_st_t fill_state(logic [2:0] t);
        unique case (t)
            3'(IM_DATAM): return LN_M;
            3'(IM_DATAE): return LN_E;
            default:      return LN_S;
        endcase
    endfunction

endpackage

// File: rtl/acc_line_store.sv
module acc_line_store
    import acc_cc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [$clog2(LINES)-1:0] a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [$clog2(LINES)-1:0] b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  line_st_t          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    line_st_t          st_mem   [LINES];
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_mem[i] <= LN_I;
        end else if (wr_en) begin
            st_mem[wr_idx] <= wr_st;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign a_st   = st_mem[a_idx];
    assign a_tag  = tag_mem[a_idx];
    assign a_data = data_mem[a_idx];
    assign b_st   = st_mem[b_idx];
    assign b_tag  = tag_mem[b_idx];
    assign b_data = data_mem[b_idx];
endmodule

// File: rtl/acc_inv_reply.sv
module acc_inv_reply
    import acc_cc_pkg::*;
(
    input  line_st_t st,
    input  logic     tag_hit,
    output out_msg_t reply,
    output logic     drop_line
);
    always_comb begin
        reply     = OM_INVACK;
        drop_line = 1'b0;
        if (tag_hit) begin
            unique case (st)
                LN_M: begin reply = OM_DIRTYWB; drop_line = 1'b1; end
                LN_E: begin reply = OM_CLEANWB; drop_line = 1'b1; end
                LN_S: begin reply = OM_INVACK;  drop_line = 1'b1; end
                default: begin reply = OM_INVACK; drop_line = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/acc_cache_ctrl.sv
module acc_cache_ctrl
    import acc_cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ack,
    output logic [DATA_W-1:0] core_rdata,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic              in_valid,
    input  logic [2:0]        in_type,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_t fsm_q, fsm_d;
    logic [IDX_W-1:0] busy_q, busy_d;

    logic [IDX_W-1:0] c_idx, i_idx, a_idx;
    logic [TAG_W-1:0] c_tag, i_tag;

    line_st_t          a_st, b_st, wr_st;
    logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
    logic [DATA_W-1:0] a_data, b_data, wr_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;

    out_msg_t inv_rep;
    logic     inv_drop;

    logic              ov_d, ack_d;
    out_msg_t          ot_d, ot_q;
    logic [ADDR_W-1:0] oa_d;
    logic [DATA_W-1:0] od_d, rd_d;

    logic inv_now, core_hit;

    assign c_idx = core_addr[IDX_W-1:0];
    assign c_tag = core_addr[ADDR_W-1:IDX_W];
    assign i_idx = in_addr[IDX_W-1:0];
    assign i_tag = in_addr[ADDR_W-1:IDX_W];
    assign a_idx = (fsm_q == C_IDLE) ? c_idx : busy_q;
    assign inv_now  = in_valid && (in_type == 3'(IM_INV));
    assign core_hit = holds_copy(a_st) && (a_tag == c_tag);

    acc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(i_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
        .wr_tag(wr_tag), .wr_data(wr_data)
    );

    acc_inv_reply u_inv (
        .st(b_st), .tag_hit(b_tag == i_tag),
        .reply(inv_rep), .drop_line(inv_drop)
    );

    // next-state and message decisions
    always_comb begin
        fsm_d   = fsm_q;
        busy_d  = busy_q;
        wr_en   = 1'b0;
        wr_idx  = a_idx;
        wr_st   = a_st;
        wr_tag  = a_tag;
        wr_data = a_data;
        ov_d    = 1'b0;
        ot_d    = OM_GETS;
        oa_d    = '0;
        od_d    = '0;
        ack_d   = 1'b0;
        rd_d    = core_rdata;
        if (inv_now) begin
            ov_d = 1'b1;
            ot_d = inv_rep;
            oa_d = in_addr;
            od_d = b_data;
            if (inv_drop) begin
                wr_en   = 1'b1;
                wr_idx  = i_idx;
                wr_st   = LN_I;
                wr_tag  = b_tag;
                wr_data = b_data;
            end
        end else begin
            unique case (fsm_q)
                C_IDLE: begin
                    if (core_req && !in_valid && !core_ack) begin
                        if (core_hit && !core_we) begin
                            ack_d = 1'b1;
                            rd_d  = a_data;
                        end else if (core_hit && a_st != LN_S) begin
                            wr_en   = 1'b1;
                            wr_st   = LN_M;
                            wr_data = core_wdata;
                            ack_d   = 1'b1;
                        end else if (core_hit) begin
                            ov_d   = 1'b1;
                            ot_d   = OM_GETM;
                            oa_d   = core_addr;
                            wr_en  = 1'b1;
                            wr_st  = LN_B;
                            busy_d = c_idx;
                            fsm_d  = C_WAIT_FILL;
                        end else if (!holds_copy(a_st)) begin
                            ov_d   = 1'b1;
                            ot_d   = core_we ? OM_GETM : OM_GETS;
                            oa_d   = core_addr;
                            wr_en  = 1'b1;
                            wr_st  = LN_B;
                            wr_tag = c_tag;
                            busy_d = c_idx;
                            fsm_d  = C_WAIT_FILL;
                        end else begin
                            ov_d   = 1'b1;
                            ot_d   = put_for(a_st);
                            oa_d   = {a_tag, c_idx};
                            od_d   = a_data;
                            wr_en  = 1'b1;
                            wr_st  = LN_B;
                            busy_d = c_idx;
                            fsm_d  = C_WAIT_WB;
                        end
                    end
                end
                C_WAIT_WB: begin
                    if (in_valid && in_type == 3'(IM_WBACK)) begin
                        wr_en = 1'b1;
                        wr_st = LN_I;
                        fsm_d = C_IDLE;
                    end
                end
                C_WAIT_FILL: begin
                    if (in_valid && in_type <= 3'(IM_DATAM)) begin
                        wr_en   = 1'b1;
                        wr_st   = fill_state(in_type);
                        wr_data = in_data;
                        fsm_d   = C_IDLE;
                    end
                end
                default: fsm_d = C_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q  <= C_IDLE;
            busy_q <= '0;
        end else begin
            fsm_q  <= fsm_d;
            busy_q <= busy_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            ot_q       <= OM_GETS;
            out_addr   <= '0;
            out_data   <= '0;
            core_ack   <= 1'b0;
            core_rdata <= '0;
        end else begin
            out_valid  <= ov_d;
            ot_q       <= ot_d;
            out_addr   <= oa_d;
            out_data   <= od_d;
            core_ack   <= ack_d;
            core_rdata <= rd_d;
        end
    end

    assign out_type = ot_q;
endmodule

// File: rtl/acc_cc_checker.sv
module acc_cc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       core_req,
    input logic       core_ack,
    input logic       out_valid,
    input logic [2:0] out_type,
    input logic       in_valid,
    input logic [2:0] in_type,
    input logic [1:0] fsm_q
);
    p_ack_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !core_ack);

    p_get_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type <= 3'd1) |-> $past(core_req));

    p_inv_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 3'd4) |=> (out_valid && out_type >= 3'd5));

    p_reply_needs_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type >= 3'd5) |-> $past(in_valid && in_type == 3'd4));

    p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q != 2'd0) |-> !core_ack);

    p_request_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type <= 3'd4) |-> $past(fsm_q == 2'd0));

    p_put_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == 2'd1 && !(in_valid && in_type == 3'd3)) |=> (fsm_q == 2'd1));
endmodule

bind acc_cache_ctrl acc_cc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_ack(core_ack),
    .out_valid(out_valid), .out_type(out_type), .in_valid(in_valid),
    .in_type(in_type), .fsm_q(fsm_q)
);

// File: tb/sim_acc_cache_ctrl.sv
module sim_acc_cache_ctrl;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] GETS = 3'd0, GETM = 3'd1, PUTS = 3'd2, PUTE = 3'd3,
                           PUTM = 3'd4, INVACK = 3'd5, CLEANWB = 3'd6, DIRTYWB = 3'd7;
    localparam logic [2:0] DATAS = 3'd0, DATAE = 3'd1, DATAM = 3'd2,
                           WBACK = 3'd3, INV = 3'd4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0;
    logic [7:0]  core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_ack;
    logic [31:0] core_rdata;
    logic        out_valid;
    logic [2:0]  out_type;
    logic [7:0]  out_addr;
    logic [31:0] out_data;
    logic        in_valid = 1'b0;
    logic [2:0]  in_type = '0;
    logic [7:0]  in_addr = '0;
    logic [31:0] in_data = '0;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_ack(core_ack),
        .core_rdata(core_rdata), .out_valid(out_valid), .out_type(out_type),
        .out_addr(out_addr), .out_data(out_data), .in_valid(in_valid),
        .in_type(in_type), .in_addr(in_addr), .in_data(in_data)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_in(input logic [2:0] t, input logic [7:0] a, input logic [31:0] d);
        in_valid = 1'b1; in_type = t; in_addr = a; in_data = d;
        step();
        in_valid = 1'b0;
    endtask

    task automatic ask(input logic we, input logic [7:0] a, input logic [31:0] d);
        core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    endtask

    task automatic done_op();
        core_req = 1'b0;
        step();
    endtask

    task automatic expect_out(input logic [2:0] t, input logic [7:0] a, input string rq);
        chk(out_valid === 1'b1, rq, "out_valid", {31'd0, out_valid}, 32'd1);
        chk(out_type === t, rq, "out_type", {29'd0, out_type}, {29'd0, t});
        chk(out_addr === a, rq, "out_addr", {24'd0, out_addr}, {24'd0, a});
    endtask

    task automatic wait_ack(input logic chk_data, input logic [31:0] d, input string rq);
        bit got = 0;
        for (int i = 0; i < 3 && !got; i++) begin
            step();
            if (core_ack) got = 1;
        end
        chk(got, rq, "core_ack after fill", {31'd0, got}, 32'd1);
        if (chk_data) chk(core_rdata === d, rq, "core_rdata", core_rdata, d);
    endtask

    // miss: Get, fill, ack
    task automatic miss_fill(input logic we, input logic [7:0] a, input logic [31:0] wd,
                             input logic [2:0] fill, input logic [31:0] fd, input string rq);
        ask(we, a, wd);
        step();
        expect_out(we ? GETM : GETS, a, rq);
        send_in(fill, a, fd);
        wait_ack(!we, fd, rq);
        done_op();
    endtask

    task automatic hit_load(input logic [7:0] a, input logic [31:0] exp, input string rq);
        ask(1'b0, a, 32'd0);
        step();
        chk(core_ack === 1'b1, rq, "hit ack", {31'd0, core_ack}, 32'd1);
        chk(out_valid === 1'b0, rq, "hit no message", {31'd0, out_valid}, 32'd0);
        chk(core_rdata === exp, rq, "hit data", core_rdata, exp);
        done_op();
    endtask

    task automatic inv_expect(input logic [7:0] a, input logic [2:0] t,
                              input logic [31:0] d, input string rq);
        send_in(INV, a, 32'd0);
        expect_out(t, a, rq);
        if (t != INVACK) chk(out_data === d, rq, "writeback data", out_data, d);
    endtask

    task automatic t_reset();
        chk(core_ack === 1'b0, "R1", "ack at reset", {31'd0, core_ack}, 32'd0);
        chk(out_valid === 1'b0, "R1", "out at reset", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_miss_and_hit();
        miss_fill(1'b0, 8'h10, 32'd0, DATAE, 32'h0000A5A5, "R1 R2 R3");
        hit_load(8'h10, 32'h0000A5A5, "R4");
        miss_fill(1'b1, 8'h3C, 32'h0000BEEF, DATAM, 32'd0, "R2 store");
        inv_expect(8'h3C, DIRTYWB, 32'h0000BEEF, "R3 R9 DataM store");
    endtask

    task automatic t_store_e_silent();
        ask(1'b1, 8'h10, 32'h00001234);
        step();
        chk(core_ack === 1'b1, "R5", "store hit ack", {31'd0, core_ack}, 32'd1);
        chk(out_valid === 1'b0, "R5", "store hit E silent", {31'd0, out_valid}, 32'd0);
        done_op();
        inv_expect(8'h10, DIRTYWB, 32'h00001234, "R5 R9");
        miss_fill(1'b0, 8'h10, 32'd0, DATAS, 32'h00000077, "R9 line gone");
    endtask

    task automatic t_upgrade();
        ask(1'b1, 8'h10, 32'h00000099);
        step();
        expect_out(GETM, 8'h10, "R6");
        chk(core_ack === 1'b0, "R6", "no ack at upgrade", {31'd0, core_ack}, 32'd0);
        repeat (2) begin
            step();
            chk(core_ack === 1'b0 && out_valid === 1'b0, "R6", "stall during upgrade",
                {30'd0, core_ack, out_valid}, 32'd0);
        end
        send_in(DATAM, 8'h10, 32'h00000077);
        wait_ack(1'b0, 32'd0, "R6");
        done_op();
        inv_expect(8'h10, DIRTYWB, 32'h00000099, "R6 store applied");
    endtask

    task automatic t_inv_replies();
        miss_fill(1'b0, 8'h21, 32'd0, DATAS, 32'h21212121, "R3");
        inv_expect(8'h21, INVACK, 32'd0, "R9 from S");
        miss_fill(1'b0, 8'h22, 32'd0, DATAE, 32'h22222222, "R3");
        inv_expect(8'h22, CLEANWB, 32'h22222222, "R9 from E");
        miss_fill(1'b0, 8'h23, 32'd0, DATAM, 32'h23232323, "R3");
        inv_expect(8'h23, DIRTYWB, 32'h23232323, "R9 from M");
        miss_fill(1'b0, 8'h21, 32'd0, DATAS, 32'h00000001, "R9 refetch after inv");
    endtask

    task automatic evict(input logic we, input logic [7:0] na, input logic [31:0] wd,
                         input logic [7:0] oa, input logic [2:0] put, input logic [31:0] pd,
                         input logic [2:0] fill, input logic [31:0] fd, input string rq);
        ask(we, na, wd);
        step();
        expect_out(put, oa, rq);
        if (put == PUTM) chk(out_data === pd, rq, "PutM data", out_data, pd);
        repeat (3) begin
            step();
            chk(out_valid === 1'b0 && core_ack === 1'b0, "R8", "wait for wb ack",
                {30'd0, core_ack, out_valid}, 32'd0);
        end
        send_in(WBACK, oa, 32'd0);
        step();
        expect_out(we ? GETM : GETS, na, rq);
        send_in(fill, na, fd);
        wait_ack(!we, fd, rq);
        done_op();
    endtask

    task automatic t_evictions();
        miss_fill(1'b0, 8'h05, 32'd0, DATAM, 32'h00000055, "R3");
        evict(1'b0, 8'h15, 32'd0, 8'h05, PUTM, 32'h00000055, DATAS, 32'h00000066, "R7 PutM");
        evict(1'b0, 8'h25, 32'd0, 8'h15, PUTS, 32'd0, DATAE, 32'h00000077, "R7 PutS");
        evict(1'b1, 8'h35, 32'h00003535, 8'h25, PUTE, 32'd0, DATAM, 32'd0, "R7 PutE");
        inv_expect(8'h35, DIRTYWB, 32'h00003535, "R7 store after evict");
    endtask

    task automatic t_inv_during_put();
        miss_fill(1'b0, 8'h06, 32'd0, DATAE, 32'h00000606, "R3");
        ask(1'b0, 8'h16, 32'd0);
        step();
        expect_out(PUTE, 8'h06, "R10");
        inv_expect(8'h06, INVACK, 32'd0, "R10");
        step();
        chk(out_valid === 1'b0 && core_ack === 1'b0, "R10", "still waiting",
            {30'd0, core_ack, out_valid}, 32'd0);
        send_in(WBACK, 8'h06, 32'd0);
        step();
        expect_out(GETS, 8'h16, "R10 get after ack");
        send_in(DATAS, 8'h16, 32'h00001616);
        wait_ack(1'b1, 32'h00001616, "R10");
        done_op();
    endtask

    task automatic t_inv_absent();
        inv_expect(8'h26, INVACK, 32'd0, "R11 other tag");
        hit_load(8'h16, 32'h00001616, "R11 line kept");
        inv_expect(8'h0A, INVACK, 32'd0, "R11 invalid line");
    endtask

    task automatic t_priority();
        ask(1'b0, 8'h40, 32'd0);
        in_valid = 1'b1; in_type = INV; in_addr = 8'h0B; in_data = '0;
        step();
        in_valid = 1'b0;
        expect_out(INVACK, 8'h0B, "R12 message first");
        chk(core_ack === 1'b0, "R12", "core deferred", {31'd0, core_ack}, 32'd0);
        step();
        expect_out(GETS, 8'h40, "R12 core later");
        send_in(DATAE, 8'h40, 32'h00004040);
        wait_ack(1'b1, 32'h00004040, "R12");
        done_op();
    endtask

    task automatic t_ack_pulse();
        ask(1'b0, 8'h40, 32'd0);
        step();
        chk(core_ack === 1'b1, "R13", "first ack", {31'd0, core_ack}, 32'd1);
        step();
        chk(core_ack === 1'b0, "R13", "ack one cycle", {31'd0, core_ack}, 32'd0);
        step();
        chk(core_ack === 1'b1, "R13", "held request served again", {31'd0, core_ack}, 32'd1);
        done_op();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_miss_and_hit();
        t_store_e_silent();
        t_upgrade();
        t_inv_replies();
        t_evictions();
        t_inv_during_put();
        t_inv_absent();
        t_priority();
        t_ack_pulse();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule